// File: doc/BRIEF.md
# Over-Current Fault Latch with Debounce

This block holds the protection logic of a phase current sensor. A one-bit over-current flag from an upstream magnitude comparator is filtered by a debounce counter. A flag that stays high long enough makes the block pull its active-low fault pin and latch that state. While the fault is latched, the block stops pulling the shared PWM data pin, so an external pull-up holds that pin high.

The latch is cleared through the PWM pin itself. Something outside the block must hold that pin low for a minimum number of clock cycles while the block is not driving it. After the clear, the block waits for the next SYNC edge. If the flag is still high at that edge, the fault comes back at once, without a new debounce. If the flag is low, the block returns to idle. When the fault pin is wired to the PWM pin, the fault's own pull-down clears the latch, which gives automatic retry at the SYNC rate.

The pads are modelled as output enables: a 1 means the pin is pulled low. The sensed pin level comes back as an input. Debounce and reset intervals are parameters counted in system clocks.

Top module: `ocp_fault_latch`

## Requirements
- R1: During a cycle with `rst` high and after it, `fault_oe_o` is 0 and the block is idle, with no debounce progress.
- R2: `fault_oe_o` goes to 1 only after `oc_flag_i` has been sampled high on DEB_CYCLES+1 consecutive rising clock edges. After exactly DEB_CYCLES such samples it is still 0.
- R3: A single low sample of `oc_flag_i` restarts the debounce, so a later run of DEB_CYCLES high samples does not assert the fault.
- R4: Once set, `fault_oe_o` stays 1 whatever `oc_flag_i` and SYNC do, until the clearing condition of R6 is met.
- R5: While `fault_oe_o` is 1, `pwm_oe_o` is 0 even with `pwm_req_i` at 1.
- R6: The latch clears only after `pwm_pin_i` is sampled low on RST_CYCLES consecutive edges while `pwm_oe_o` is 0. A high sample restarts the count, so a low run of RST_CYCLES-1 samples leaves the fault set.
- R7: After a clear, the fault output stays 0 until the next SYNC edge. With the default edge mode, a rise and a fall both count. At that edge the fault re-asserts in the following cycle if `oc_flag_i` is 1, or the block returns to idle if it is 0.
- R8: After a return to idle, a new fault needs the full debounce of R2.
- R9: When no fault is latched, `pwm_oe_o` equals `pwm_req_i` in the same cycle, including the wait for a SYNC edge after a clear.
- R10: With the fault pin wired to the PWM pin and the flag held high, the fault clears itself RST_CYCLES cycles after it rises, and it re-asserts at each later SYNC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag_i | input | 1 | Over-current flag from the magnitude comparator, synchronous to clk |
| sync_i | input | 1 | SYNC reference signal, synchronous to clk |
| pwm_req_i | input | 1 | PWM data from the modulator; 1 requests a low drive of the PWM pin |
| pwm_pin_i | input | 1 | Sensed level of the PWM pin |
| pwm_oe_o | output | 1 | 1 pulls the PWM pin low |
| fault_oe_o | output | 1 | 1 pulls the active-low fault pin low (fault active) |

## Verification
The embedded assertions watch several rules on every cycle. They check that the fault follows a high flag, that the PWM drive is off while the fault is latched, and that a latched fault never releases after a high sample of the PWM pin. They also check that a release always follows a low sample, and that the wait state only ends on a SYNC edge. The exact debounce and reset lengths, the restart of both counters, the choice between re-fault and idle at the SYNC edge, and the auto-reset loop through a wired pin depend on the order of stimulus. Only the bench's scenarios, compared cycle by cycle against the behavioural model, can show those.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEBOUNCE = 2'd1,
        ST_FAULT    = 2'd2,
        ST_REARM    = 2'd3
    } ocp_state_e;

    typedef enum logic [1:0] {
        EDGE_BOTH = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } ocp_edge_e;

    typedef struct packed {
        logic fault_drv;
        logic pwm_drv;
    } ocp_drive_t;

    function automatic int run_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

    function automatic logic is_latched(input ocp_state_e s);
        return s == ST_FAULT;
    endfunction

    function automatic logic is_armed(input ocp_state_e s);
        return (s == ST_IDLE) || (s == ST_DEBOUNCE);
    endfunction

endpackage

// File: rtl/ocp_run_counter.sv
module ocp_run_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic hit_o
);
    localparam int W = ocp_pkg::run_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign hit_o = run_i && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || hit_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (LIMIT > 1) begin : g_chk
            // R3 / R6: a completed run is never reached without a run sample just before it
            assert_hit_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
                hit_o |-> $past(run_i));
        end
    endgenerate

endmodule

// File: rtl/ocp_sync_edge.sv
module ocp_sync_edge
    import ocp_pkg::*;
#(
    parameter ocp_edge_e EDGE_MODE = EDGE_BOTH
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic edge_o
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_i;
        end
    end

    generate
        if (EDGE_MODE == EDGE_RISE) begin : g_rise
            assign edge_o = sync_i && !sync_q;
        end else if (EDGE_MODE == EDGE_FALL) begin : g_fall
            assign edge_o = !sync_i && sync_q;
        end else begin : g_both
            assign edge_o = sync_i ^ sync_q;
        end
    endgenerate

endmodule

// File: rtl/ocp_fault_fsm.sv
module ocp_fault_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       oc_flag_i,
    input  logic       deb_hit_i,
    input  logic       clr_hit_i,
    input  logic       sync_edge_i,
    output ocp_state_e state_o
);
    ocp_state_e state_q;
    ocp_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (deb_hit_i) begin
                    state_d = ST_FAULT;
                end else if (oc_flag_i) begin
                    state_d = ST_DEBOUNCE;
                end
            end
            ST_DEBOUNCE: begin
                if (deb_hit_i) begin
                    state_d = ST_FAULT;
                end else if (!oc_flag_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (clr_hit_i) begin
                    state_d = ST_REARM;
                end
            end
            ST_REARM: begin
                if (sync_edge_i) begin
                    state_d = oc_flag_i ? ST_FAULT : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R7: the wait after a clear only ends on a SYNC edge
    assert_rearm_waits_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REARM && !sync_edge_i) |=> (state_q == ST_REARM));

    // R7: the edge decision follows the flag
    assert_rearm_decides_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REARM && sync_edge_i && oc_flag_i) |=> (state_q == ST_FAULT));

endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
    import ocp_pkg::*;
#(
    parameter int        DEB_CYCLES = 175,
    parameter int        RST_CYCLES = 25,
    parameter ocp_edge_e EDGE_MODE  = EDGE_BOTH
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_flag_i,
    input  logic sync_i,
    input  logic pwm_req_i,
    input  logic pwm_pin_i,
    output logic pwm_oe_o,
    output logic fault_oe_o
);
    localparam int DEB_RUN = DEB_CYCLES + 1;
    localparam int CLR_RUN = (RST_CYCLES < 1) ? 1 : RST_CYCLES;

    ocp_state_e state;
    ocp_drive_t drv;
    logic       deb_run, deb_hit;
    logic       clr_run, clr_hit;
    logic       sync_edge;

    assign drv.fault_drv = is_latched(state);
    assign drv.pwm_drv   = pwm_req_i && !drv.fault_drv;

    assign deb_run = oc_flag_i && is_armed(state);
    assign clr_run = is_latched(state) && !drv.pwm_drv && !pwm_pin_i;

    ocp_run_counter #(.LIMIT(DEB_RUN)) u_deb_cnt (
        .clk   (clk),
        .rst   (rst),
        .run_i (deb_run),
        .hit_o (deb_hit)
    );

    ocp_run_counter #(.LIMIT(CLR_RUN)) u_clr_cnt (
        .clk   (clk),
        .rst   (rst),
        .run_i (clr_run),
        .hit_o (clr_hit)
    );

    ocp_sync_edge #(.EDGE_MODE(EDGE_MODE)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .edge_o (sync_edge)
    );

    ocp_fault_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .oc_flag_i   (oc_flag_i),
        .deb_hit_i   (deb_hit),
        .clr_hit_i   (clr_hit),
        .sync_edge_i (sync_edge),
        .state_o     (state)
    );

    assign pwm_oe_o   = drv.pwm_drv;
    assign fault_oe_o = drv.fault_drv;

    // R1: reset leaves the fault inactive
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !fault_oe_o);

    // R2: a fault only starts from a sampled high flag
    assert_rise_needs_flag_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_oe_o) |-> $past(oc_flag_i));

    // R4: a high PWM pin never releases a latched fault
    assert_hold_latched_R4: assert property (@(posedge clk) disable iff (rst)
        (fault_oe_o && pwm_pin_i) |=> fault_oe_o);

    // R5: no PWM drive while the fault is active
    assert_pwm_released_R5: assert property (@(posedge clk) disable iff (rst)
        fault_oe_o |-> !pwm_oe_o);

    // R6: every release follows a low sample of the PWM pin
    assert_clear_needs_low_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_oe_o) |-> $past(!pwm_pin_i));

endmodule

// File: tb/ocp_fault_latch_tb.sv
module ocp_fault_latch_tb;
    import ocp_pkg::*;

    localparam int DEB = 6;
    localparam int RST = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flag = 1'b0;
    logic sync = 1'b0;
    logic req = 1'b0;
    logic ext_low = 1'b0;
    logic tie = 1'b0;
    logic pwm_oe, fault_oe;
    wire  pin;

    assign pin = !(pwm_oe || ext_low || (tie && fault_oe));

    always #10 clk = ~clk;

    ocp_fault_latch #(.DEB_CYCLES(DEB), .RST_CYCLES(RST), .EDGE_MODE(EDGE_BOTH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .oc_flag_i  (flag),
        .sync_i     (sync),
        .pwm_req_i  (req),
        .pwm_pin_i  (pin),
        .pwm_oe_o   (pwm_oe),
        .fault_oe_o (fault_oe)
    );

    int    total = 0;
    int    bad = 0;
    string cur = "R1";
    bit    done = 1'b0;

    // behavioural reference: run lengths and two flags
    int m_hi, m_lo;
    bit m_fault, m_wait, m_sprev, m_edge, m_pin;

    always @(posedge clk) begin
        if (rst) begin
            m_hi = 0; m_lo = 0; m_fault = 0; m_wait = 0; m_sprev = 0;
        end else begin
            m_edge  = (sync != m_sprev);
            m_sprev = sync;
            m_pin   = !((req && !m_fault) || ext_low || (tie && m_fault));
            if (m_fault) begin
                m_lo = m_pin ? 0 : m_lo + 1;
                if (m_lo >= RST) begin
                    m_fault = 0; m_wait = 1; m_lo = 0;
                end
            end else if (m_wait) begin
                if (m_edge) begin
                    m_wait = 0;
                    m_fault = flag;
                end
            end else begin
                m_hi = flag ? m_hi + 1 : 0;
                if (m_hi > DEB) begin
                    m_fault = 1; m_hi = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk(cur, fault_oe, m_fault);
            chk(cur, pwm_oe, req && !m_fault);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(input string tag, input logic exp);
        #3;
        chk(tag, fault_oe, exp);
    endtask

    initial begin
        cyc(3);
        look("R1", 1'b0);
        req = 1'b1;
        #1 chk("R9", pwm_oe, 1'b1);
        rst = 1'b0;

        // R2: exact debounce length
        cyc(1);
        cur = "R2"; flag = 1'b1;
        cyc(DEB);  look("R2", 1'b0);
        cyc(1);    look("R2", 1'b1);

        // R4 / R5: latched against flag and SYNC
        cur = "R4"; flag = 1'b0;
        cyc(5);    look("R4", 1'b1);
        chk("R5", pwm_oe, 1'b0);
        sync = 1'b1;
        cyc(2);    look("R4", 1'b1);

        // R6: short low runs and restart
        cur = "R6"; ext_low = 1'b1;
        cyc(RST - 1); ext_low = 1'b0;
        cyc(1);    look("R6", 1'b1);
        ext_low = 1'b1;
        cyc(RST - 1); ext_low = 1'b0;
        cyc(1);    look("R6", 1'b1);
        ext_low = 1'b1;
        cyc(RST);  look("R6", 1'b0);
        ext_low = 1'b0;

        // R9 / R7: waiting for SYNC, then back to idle on a falling edge
        cur = "R9";
        #1 chk("R9", pwm_oe, 1'b1);
        cyc(3);    look("R7", 1'b0);
        cur = "R7"; sync = 1'b0;
        cyc(1);    look("R7", 1'b0);

        // R8 / R3: full debounce needed again, restart on a drop
        cur = "R8"; flag = 1'b1;
        cyc(DEB);  look("R8", 1'b0);
        cur = "R3"; flag = 1'b0;
        cyc(1);    flag = 1'b1;
        cyc(DEB);  look("R3", 1'b0);
        cyc(1);    look("R3", 1'b1);

        // R7: re-fault at SYNC edges while the flag stays high
        cur = "R7"; ext_low = 1'b1;
        cyc(RST);  ext_low = 1'b0;
        look("R7", 1'b0);
        cyc(3);    look("R7", 1'b0);
        sync = 1'b1;
        cyc(1);    look("R7", 1'b1);
        ext_low = 1'b1;
        cyc(RST);  ext_low = 1'b0;
        look("R7", 1'b0);
        sync = 1'b0;
        cyc(1);    look("R7", 1'b1);
        flag = 1'b0; ext_low = 1'b1;
        cyc(RST);  ext_low = 1'b0;
        sync = 1'b1;
        cyc(1);    look("R7", 1'b0);

        // R10: auto-reset through a wired pin
        cur = "R10"; tie = 1'b1; flag = 1'b1;
        cyc(DEB + 1); look("R10", 1'b1);
        cyc(RST);  look("R10", 1'b0);
        sync = ~sync;
        cyc(1);    look("R10", 1'b1);
        cyc(RST);  look("R10", 1'b0);
        flag = 1'b0; sync = ~sync;
        cyc(1);    look("R10", 1'b0);
        cyc(DEB + 3); look("R10", 1'b0);
        tie = 1'b0;

        cyc(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule